// File: doc/BRIEF.md
# SPI Page-Buffer Program Target

This block is the slave side of a serial flash that accepts a buffered page-program command over a four-wire SPI link. The host holds chip select low, clocks in an opcode, a 24-bit page/byte address and then any number of data bytes. The bytes land in an on-chip SRAM page buffer, starting at the given byte offset. The write position advances by one for each byte and wraps at the end of the buffer.

When chip select goes high after a well-formed command, a self-timed engine erases the selected page of a small on-chip page array and then copies the whole buffer into it. While this runs, a status-read command returns a ready flag in bit 7. A plain read port exposes the page array to the rest of the chip.

All SPI pins are sampled with the system clock through two-flop synchronisers. SCK must be slow enough that each of its levels lasts several system clocks.

Top module: `spi_page_prog`

## Requirements
- R1: After reset, spi_miso is 0, no program operation is running, and a status read returns 0x80.
- R2: Opcode 0x83 starts a page program. It is followed by 24 address bits, MSB first, sampled on rising SCK. Bits [8:0] give the starting byte offset and bits [9+PAGE_BITS-1:9] give the page number. An offset at or above PAGE_BYTES starts at 0.
- R3: Each complete data byte is MSB first. The first byte is stored at the starting offset, the next at offset+1, and so on.
- R4: After buffer location PAGE_BYTES-1, the next data byte goes to location 0.
- R5: On the rising edge of chip select after a complete address and a whole number of data bytes (zero included), the selected page is erased and then loaded with the entire buffer. Buffer locations not written by this command keep their earlier contents.
- R6: A program operation keeps the block busy for exactly PROG_CYCLES system clocks. The status byte is {ready, 7'b0}, where ready is 0 while busy and 1 otherwise.
- R7: Opcode 0xD7 makes the block shift the status byte out on spi_miso, MSB first, one bit per falling SCK edge, repeating for as long as chip select stays low. In every other state spi_miso is 0.
- R8: Any other opcode is ignored until chip select rises: no buffer write and no program.
- R9: If chip select rises before all 24 address bits have arrived, no program starts and the page array is unchanged.
- R10: If chip select rises partway through a data byte, that partial byte is discarded and no program starts. Bytes already completed stay in the buffer.
- R11: A page-program command received while busy is ignored entirely: it writes no buffer location and starts no second program.
- R12: rd_data returns the byte at offset rd_byte of page rd_page of the page array, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial status data to the host |
| rd_page | input | PAGE_BITS | Page select for the array read port |
| rd_byte | input | OFS_W | Byte offset for the array read port |
| rd_data | output | 8 | Byte read from the page array |

## Verification
The checker watches several properties on every cycle:
- a program only starts from the idle state;
- busy lasts exactly PROG_CYCLES clocks and only rises after a start pulse;
- buffer writes never fall outside the buffer and never happen while busy;
- spi_miso stays 0 outside a status read.

Other behaviours depend on data and on how commands are framed, so only the bench's scenarios can show them:
- that bytes land at the right offsets and wrap;
- that unwritten buffer bytes carry over into the page;
- that truncated or unknown commands leave the page array untouched.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  localparam logic [7:0] OPC_PROGRAM = 8'h83;
  localparam logic [7:0] OPC_STATUS  = 8'hD7;

  typedef enum logic [2:0] {F_OPC, F_ADDR, F_DATA, F_STAT, F_SKIP} fe_state_t;
  typedef enum logic [1:0] {E_IDLE, E_ERASE, E_COPY, E_HOLD} eng_state_t;

  // next buffer position, wrapping at the buffer size
  function automatic int unsigned wrap_next(int unsigned pos, int unsigned size);
    return (pos + 1 == size) ? 0 : pos + 1;
  endfunction

  // starting offset; out-of-range offsets begin at 0
  function automatic int unsigned start_ofs(int unsigned ofs, int unsigned size);
    return (ofs < size) ? ofs : 0;
  endfunction

  function automatic logic [7:0] status_byte(logic ready);
    return {ready, 7'b0};
  endfunction
endpackage

// File: rtl/ppt_sync.sv
module ppt_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta  <= RST_VAL;
      d_out <= RST_VAL;
    end else begin
      meta  <= d_in;
      d_out <= meta;
    end
  end
endmodule

// File: rtl/ppt_front.sv
module ppt_front
  import ppt_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int OFS_FIELD  = 9,
  parameter int PAGE_BITS  = 2,
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sck_rise,
  input  logic                 sck_fall,
  input  logic                 cs_low,
  input  logic                 cs_rise,
  input  logic                 mosi_s,
  input  logic                 busy,
  output logic                 buf_wr,
  output logic [OFS_W-1:0]     buf_waddr,
  output logic [7:0]           buf_wdata,
  output logic                 go,
  output logic [PAGE_BITS-1:0] go_page,
  output logic                 miso,
  output logic                 in_status
);
  fe_state_t              st;
  logic [4:0]             cnt;
  logic [7:0]             sh;
  logic [23:0]            addr;
  logic [OFS_W-1:0]       ptr;
  logic [PAGE_BITS-1:0]   page_q;
  logic [2:0]             sidx;
  logic [7:0]             nbyte;
  logic [23:0]            naddr;
  logic [7:0]             stat_b;

  assign nbyte     = {sh[6:0], mosi_s};
  assign naddr     = {addr[22:0], mosi_s};
  assign stat_b    = status_byte(!busy);
  assign in_status = (st == F_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= F_OPC; cnt <= '0; sh <= '0; addr <= '0; ptr <= '0; page_q <= '0;
      sidx <= '0; miso <= 1'b0; buf_wr <= 1'b0; buf_waddr <= '0; buf_wdata <= '0;
      go <= 1'b0; go_page <= '0;
    end else begin
      buf_wr <= 1'b0;
      go     <= 1'b0;
      if (!cs_low) begin
        st <= F_OPC; cnt <= '0; miso <= 1'b0; sidx <= '0;
        if (cs_rise && st == F_DATA && cnt[2:0] == 3'd0) begin
          go      <= 1'b1;
          go_page <= page_q;
        end
      end else begin
        if (sck_rise) begin
          sh  <= nbyte;
          cnt <= cnt + 5'd1;
          case (st)
            F_OPC: if (cnt == 5'd7) begin
              cnt <= '0;
              if (nbyte == OPC_PROGRAM && !busy) st <= F_ADDR;
              else if (nbyte == OPC_STATUS)      st <= F_STAT;
              else                               st <= F_SKIP;
            end
            F_ADDR: begin
              addr <= naddr;
              if (cnt == 5'd23) begin
                cnt    <= '0;
                st     <= F_DATA;
                page_q <= naddr[OFS_FIELD +: PAGE_BITS];
                ptr    <= OFS_W'(start_ofs(32'(naddr[OFS_FIELD-1:0]), PAGE_BYTES));
              end
            end
            F_DATA: if (cnt[2:0] == 3'd7) begin
              cnt       <= '0;
              buf_wr    <= 1'b1;
              buf_waddr <= ptr;
              buf_wdata <= nbyte;
              ptr       <= OFS_W'(wrap_next(32'(ptr), PAGE_BYTES));
            end
            default: cnt <= '0;
          endcase
        end
        if (sck_fall && st == F_STAT) begin
          miso <= stat_b[3'd7 - sidx];
          sidx <= sidx + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/ppt_engine.sv
module ppt_engine
  import ppt_pkg::*;
#(
  parameter int PAGE_BYTES  = 264,
  parameter int NUM_PAGES   = 4,
  parameter int PROG_CYCLES = 2000,
  localparam int OFS_W      = $clog2(PAGE_BYTES),
  localparam int PAGE_BITS  = $clog2(NUM_PAGES),
  localparam int AW         = $clog2(NUM_PAGES * PAGE_BYTES),
  localparam int TW         = $clog2(PROG_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [PAGE_BITS-1:0] go_page,
  output logic [OFS_W-1:0]     buf_raddr,
  input  logic [7:0]           buf_rdata,
  output logic                 busy,
  input  logic [PAGE_BITS-1:0] rd_page,
  input  logic [OFS_W-1:0]     rd_byte,
  output logic [7:0]           rd_data
);
  eng_state_t           st;
  logic [PAGE_BITS-1:0] pg;
  logic [OFS_W-1:0]     idx;
  logic [TW-1:0]        tcnt;
  logic [7:0]           mem [NUM_PAGES * PAGE_BYTES];
  logic                 mem_we;
  logic [AW-1:0]        mem_wa;
  logic [7:0]           mem_wd;
  logic                 last_idx;

  assign busy      = (st != E_IDLE);
  assign buf_raddr = idx;
  assign last_idx  = (idx == OFS_W'(PAGE_BYTES - 1));
  assign mem_we    = (st == E_ERASE) || (st == E_COPY);
  assign mem_wa    = AW'(32'(pg) * PAGE_BYTES + 32'(idx));
  assign mem_wd    = (st == E_ERASE) ? 8'hFF : buf_rdata;
  assign rd_data   = mem[AW'(32'(rd_page) * PAGE_BYTES + 32'(rd_byte))];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE; pg <= '0; idx <= '0; tcnt <= '0;
    end else if (st == E_IDLE) begin
      if (go) begin
        st <= E_ERASE; pg <= go_page; idx <= '0; tcnt <= '0;
      end
    end else begin
      tcnt <= tcnt + TW'(1);
      case (st)
        E_ERASE: if (last_idx) begin idx <= '0; st <= E_COPY; end
                 else idx <= idx + OFS_W'(1);
        E_COPY:  if (last_idx) begin idx <= '0; st <= E_HOLD; end
                 else idx <= idx + OFS_W'(1);
        default: if (tcnt == TW'(PROG_CYCLES - 1)) st <= E_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
  end
endmodule

// File: rtl/spi_page_prog.sv
module spi_page_prog
  import ppt_pkg::*;
#(
  parameter int PAGE_BYTES  = 264,
  parameter int NUM_PAGES   = 4,
  parameter int PROG_CYCLES = 2000,
  parameter int OFS_FIELD   = 9,
  localparam int OFS_W      = $clog2(PAGE_BYTES),
  localparam int PAGE_BITS  = $clog2(NUM_PAGES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sck,
  input  logic                 spi_cs_n,
  input  logic                 spi_mosi,
  output logic                 spi_miso,
  input  logic [PAGE_BITS-1:0] rd_page,
  input  logic [OFS_W-1:0]     rd_byte,
  output logic [7:0]           rd_data
);
  logic [2:0]           pins_s;
  logic                 sck_s, cs_n_s, mosi_s, sck_d, cs_n_d;
  logic                 sck_rise, sck_fall, cs_low, cs_rise;
  logic                 buf_wr, go, busy, in_status;
  logic [OFS_W-1:0]     buf_waddr, buf_raddr;
  logic [7:0]           buf_wdata, buf_rdata;
  logic [PAGE_BITS-1:0] go_page;
  logic [7:0]           pbuf [PAGE_BYTES];

  ppt_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({spi_sck, spi_cs_n, spi_mosi}), .d_out(pins_s));
  assign {sck_s, cs_n_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin sck_d <= 1'b0; cs_n_d <= 1'b1; end
    else begin sck_d <= sck_s; cs_n_d <= cs_n_s; end
  end
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_low   = ~cs_n_s;
  assign cs_rise  = cs_n_s & ~cs_n_d;

  ppt_front #(.PAGE_BYTES(PAGE_BYTES), .OFS_FIELD(OFS_FIELD), .PAGE_BITS(PAGE_BITS)) u_front (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_low(cs_low), .cs_rise(cs_rise), .mosi_s(mosi_s), .busy(busy),
    .buf_wr(buf_wr), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .go(go), .go_page(go_page), .miso(spi_miso), .in_status(in_status));

  always_ff @(posedge clk) begin
    if (buf_wr) pbuf[buf_waddr] <= buf_wdata;
  end
  assign buf_rdata = pbuf[buf_raddr];

  ppt_engine #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES), .PROG_CYCLES(PROG_CYCLES)) u_engine (
    .clk(clk), .rst_n(rst_n), .go(go), .go_page(go_page),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .busy(busy),
    .rd_page(rd_page), .rd_byte(rd_byte), .rd_data(rd_data));
endmodule

// File: rtl/spi_page_prog_chk.sv
module spi_page_prog_chk #(
  parameter int PAGE_BYTES  = 264,
  parameter int PROG_CYCLES = 2000,
  localparam int OFS_W      = $clog2(PAGE_BYTES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             busy,
  input logic             buf_wr,
  input logic [OFS_W-1:0] buf_waddr,
  input logic             in_status,
  input logic             miso
);
  int unsigned busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= 0;
    else        busy_len <= busy ? busy_len + 1 : 0;
  end

  assert_go_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
  assert_no_buf_wr_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> !busy);
  assert_busy_after_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));
  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == PROG_CYCLES));
  assert_buf_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> (32'(buf_waddr) < PAGE_BYTES));
  assert_miso_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_status |-> !miso);
endmodule

bind spi_page_prog spi_page_prog_chk #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .buf_wr(buf_wr),
  .buf_waddr(buf_waddr), .in_status(in_status), .miso(spi_miso));

// File: tb/spi_page_prog_tb.sv
`timescale 1ns/1ps
module spi_page_prog_tb;
  localparam int PB    = 264;
  localparam int NP    = 4;
  localparam int PROG  = 2000;
  localparam int HALF  = 8;

  logic clk = 0, rst_n = 0;
  logic sck = 0, cs_n = 1, mosi = 0;
  logic miso;
  logic [1:0] rd_page = '0;
  logic [8:0] rd_byte = '0;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_mem [NP][PB];
  logic [7:0] mbuf [PB];

  always #2.5 clk = ~clk;

  spi_page_prog #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .rd_page(rd_page), .rd_byte(rd_byte), .rd_data(rd_data));

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic spi_begin();
    cs_n = 0; tick(HALF);
  endtask

  task automatic spi_end();
    tick(HALF); cs_n = 1; mosi = 0; tick(4 * HALF);
  endtask

  task automatic spi_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i]; tick(HALF); sck = 1; tick(HALF); sck = 0;
    end
  endtask

  task automatic prog_head(int page, int ofs);
    spi_bits(32'h83, 8);
    spi_bits(32'((page << 9) | ofs), 24);
  endtask

  task automatic read_status(output logic [7:0] b0, output logic [7:0] b1);
    logic [15:0] v;
    spi_begin();
    spi_bits(32'hD7, 8);
    mosi = 0;
    for (int i = 15; i >= 0; i--) begin
      tick(HALF); v[i] = miso; sck = 1; tick(HALF); sck = 0;
    end
    spi_end();
    b0 = v[15:8]; b1 = v[7:0];
  endtask

  task automatic expect_status(logic [7:0] exp, string req);
    logic [7:0] b0, b1;
    read_status(b0, b1);
    check(b0 === exp, req, b0, exp);
    check(b1 === exp, req, b1, exp);
  endtask

  task automatic check_page(int page, string req);
    int bad = -1;
    logic [7:0] got = 0;
    for (int i = 0; i < PB; i++) begin
      rd_page = 2'(page); rd_byte = 9'(i); tick(1);
      if (bad < 0 && rd_data !== exp_mem[page][i]) begin bad = i; got = rd_data; end
    end
    check(bad < 0, req, got, (bad < 0) ? 0 : exp_mem[page][bad]);
  endtask

  task automatic wait_program();
    tick(PROG + 100);
  endtask

  task automatic commit(int page);
    for (int i = 0; i < PB; i++) exp_mem[page][i] = mbuf[i];
  endtask

  // R1: reset state
  task automatic t_reset();
    check(miso === 1'b0, "R1 miso after reset", miso, 0);
    expect_status(8'h80, "R1 R6 R7 status ready after reset");
  endtask

  // R2 R3 R5 R6 R12: full page from offset 0
  task automatic t_full_page();
    spi_begin(); prog_head(0, 0);
    for (int i = 0; i < PB; i++) begin
      mbuf[i] = 8'((i * 7 + 3) & 255);
      spi_bits(32'(mbuf[i]), 8);
    end
    spi_end();
    commit(0);
    expect_status(8'h00, "R6 busy during program");
    wait_program();
    expect_status(8'h80, "R6 ready after program");
    check_page(0, "R2 R3 R5 R12 full page contents");
  endtask

  // R4 R5: start near the end, wrap, old bytes carried over
  task automatic t_wrap();
    spi_begin(); prog_head(1, 262);
    mbuf[262] = 8'hA1; mbuf[263] = 8'hA2; mbuf[0] = 8'hA3;
    spi_bits(32'hA1, 8); spi_bits(32'hA2, 8); spi_bits(32'hA3, 8);
    spi_end();
    commit(1);
    wait_program();
    check_page(1, "R4 R5 wrap and carried bytes");
  endtask

  // R5 R11: empty program copies buffer; program during busy ignored
  task automatic t_busy_reject();
    spi_begin(); prog_head(2, 0); spi_end();
    commit(2);
    spi_begin(); prog_head(0, 5); spi_bits(32'h55, 8); spi_end();
    expect_status(8'h00, "R6 still busy during rejected command");
    wait_program();
    expect_status(8'h80, "R11 no second program started");
    check_page(2, "R5 zero-byte program copies buffer");
    check_page(0, "R11 rejected command left page 0");
    spi_begin(); prog_head(3, 0); spi_end();
    commit(3);
    wait_program();
    check_page(3, "R11 rejected command left buffer");
  endtask

  // R9: address cut short
  task automatic t_abort_addr();
    spi_begin(); spi_bits(32'h83, 8); spi_bits(32'h0, 10); spi_end();
    expect_status(8'h80, "R9 no program after short address");
    check_page(0, "R9 page unchanged");
  endtask

  // R10 R3: partial data byte
  task automatic t_abort_partial();
    spi_begin(); prog_head(0, 10); spi_bits(32'h3C, 8); spi_bits(32'h5, 3); spi_end();
    mbuf[10] = 8'h3C;
    expect_status(8'h80, "R10 no program after partial byte");
    check_page(0, "R10 page unchanged");
    spi_begin(); prog_head(3, 0); spi_end();
    commit(3);
    wait_program();
    check_page(3, "R10 R3 only whole byte kept in buffer");
  endtask

  // R8: unknown opcode followed by bytes that look like a program
  task automatic t_unknown();
    spi_begin(); spi_bits(32'h55, 8); prog_head(0, 0); spi_bits(32'h99, 8); spi_end();
    expect_status(8'h80, "R8 unknown opcode starts nothing");
    check_page(0, "R8 page unchanged");
  endtask

  initial begin
    tick(5); rst_n = 1; tick(5);
    t_reset();
    t_full_page();
    t_wrap();
    t_busy_reject();
    t_abort_addr();
    t_abort_partial();
    t_unknown();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule